// File: doc/BRIEF.md
# MSI Write Detector with Interrupt Masking

This block sits on the receive side of a PCIe bridge and sees simplified memory-write requests. Each request carries a header-format flag, an address and its first data word, and is accepted in any cycle where `req_valid` is high. Every request is checked in two separate ways.

The first check compares the address with a programmable MSI address. When a write with a 32-bit address (3-DW header) hits that address, the block stores the data word as the latest MSI data and sends out a single-cycle MSI pulse. The second check matches the address against a programmable window made of a base and a size mask. Writes that land in the window go out on the local write path. Writes that neither land in the window nor trigger an MSI are dropped and flagged as overruns. If software puts the MSI address inside the window, one write both goes out and raises an MSI, which gives a spurious interrupt. That outcome is allowed and is kept on purpose.

The block also holds six sticky event-status bits: poisoned data, completion abort, window overrun, non-contiguous byte enables, link down and bus-master change. An enable mask gates these bits onto a single combined interrupt line. Software reaches every register through a simple synchronous read/write port.

Top module: `msi_wr_detect`

## Requirements
- R1: After reset, all registers read as zero: status 0x40, enable 0x44, MSI address 0x48, MSI data 0x4C, window base 0x50 and window mask 0x54. `fwd_valid`, `msi_irq` and `irq_out` are low.
- R2: A valid write with `req_is64`=0 whose address equals the MSI address makes `msi_irq` high for exactly the next cycle. The same write loads `req_data` into the MSI data register, which keeps that value until the next such match.
- R3: A write with `req_is64`=1 never triggers an MSI, even if its address equals the MSI address, and it leaves the MSI data register unchanged.
- R4: A write is inside the window when `(addr & mask) == (base & mask)`. For such a write, `fwd_valid` is high in the next cycle with `fwd_addr` and `fwd_data` equal to the request's address and data. Any other write is not forwarded.
- R5: A write that both hits the MSI address and falls inside the window is forwarded and also raises `msi_irq`.
- R6: A write that is outside the window and raises no MSI sets status bit 10 (window overrun).
- R7: A matching MSI write outside the window is not forwarded and does not set bit 10.
- R8: Enable register bits 8, 9, 10, 11, 12 and 17 can be read and written, with 1 meaning enabled. All other bits of the enable register read as zero and ignore writes.
- R9: A status bit stays set until software writes 1 to that bit at offset 0x40. Event inputs map to bits 8 (`ev_poison`), 9 (`ev_cmpl_abort`), 11 (`ev_ncbe`), 12 (`ev_link_down`) and 17 (`ev_bus_master`). If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R10: `irq_out` is high exactly when some status bit and its matching enable bit are both 1.
- R11: Reads of any offset not listed in R1 return zero. Writes to the MSI data register are ignored.
- R12: Read data appears on `reg_rdata` in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present this cycle |
| req_is64 | input | 1 | Request uses a 64-bit-address (4-DW) header |
| req_addr | input | 32 | Request address (low 32 bits) |
| req_data | input | 32 | First data word of the request |
| fwd_valid | output | 1 | Forwarded write valid on the local path |
| fwd_addr | output | 32 | Forwarded write address |
| fwd_data | output | 32 | Forwarded write data |
| msi_irq | output | 1 | One-cycle MSI pulse |
| ev_poison | input | 1 | Poisoned-data event pulse |
| ev_cmpl_abort | input | 1 | Completion-abort event pulse |
| ev_ncbe | input | 1 | Non-contiguous byte-enable event pulse |
| ev_link_down | input | 1 | Link-down event pulse |
| ev_bus_master | input | 1 | Bus-master-enable event pulse |
| irq_out | output | 1 | Combined masked interrupt |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Register access is a write |
| reg_addr | input | 32 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (registered) |

## Verification
The bench runs all eight combinations of header form, window hit and MSI-address hit. This shows that forwarding, the MSI pulse, data capture and overrun flagging each depend on their own condition, so none of them leaks into another. It then flips each of the 32 address bits around an MSI address that sits inside a 4 KB window. This confirms that an MSI needs an exact match, while the window follows only the mask bits. Each event bit is then tested with its enable off and then on, and with a clear that lands in the same cycle as the event. Finally, a sweep of single bits through the enable register separates the writable bits from the reserved ones.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned W = 32;

  localparam logic [W-1:0] OFS_STAT = 32'h0000_0040;
  localparam logic [W-1:0] OFS_IER  = 32'h0000_0044;
  localparam logic [W-1:0] OFS_MAR  = 32'h0000_0048;
  localparam logic [W-1:0] OFS_MDR  = 32'h0000_004C;
  localparam logic [W-1:0] OFS_BASE = 32'h0000_0050;
  localparam logic [W-1:0] OFS_MASK = 32'h0000_0054;

  localparam int unsigned B_POISON = 8;
  localparam int unsigned B_ABORT  = 9;
  localparam int unsigned B_OVR    = 10;
  localparam int unsigned B_NCBE   = 11;
  localparam int unsigned B_LINK   = 12;
  localparam int unsigned B_BME    = 17;

  localparam logic [W-1:0] EV_MASK = (W'(1) << B_POISON) | (W'(1) << B_ABORT) |
                                     (W'(1) << B_OVR)    | (W'(1) << B_NCBE)  |
                                     (W'(1) << B_LINK)   | (W'(1) << B_BME);

  typedef struct packed {
    logic         is64;
    logic [W-1:0] addr;
    logic [W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/msi_match.sv
module msi_match
  import msi_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  wr_req_t      req,
  input  logic [W-1:0] mar,
  input  logic [W-1:0] bar_base,
  input  logic [W-1:0] bar_mask,
  output logic         fwd_valid,
  output logic [W-1:0] fwd_addr,
  output logic [W-1:0] fwd_data,
  output logic         msi_pulse,
  output logic         cap_en,
  output logic         ovr_evt
);
  logic bar_hit, msi_hit;
  logic fwd_valid_nx, msi_pulse_nx;

  always_comb begin
    bar_hit      = ((req.addr ^ bar_base) & bar_mask) == '0;
    msi_hit      = !req.is64 && (req.addr == mar);
    cap_en       = req_valid && msi_hit;
    ovr_evt      = req_valid && !bar_hit && !msi_hit;
    fwd_valid_nx = req_valid && bar_hit;
    msi_pulse_nx = cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      msi_pulse <= 1'b0;
    end else begin
      fwd_valid <= fwd_valid_nx;
      msi_pulse <= msi_pulse_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_addr <= '0;
      fwd_data <= '0;
    end else if (fwd_valid_nx) begin
      fwd_addr <= req.addr;
      fwd_data <= req.data;
    end
  end

  p_pulse_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> $past(req_valid)) else $error("msi pulse without request");

  p_no_wide_msi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> !$past(req.is64)) else $error("msi from 64-bit header");

  p_drop_or_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> !fwd_valid_nx) else $error("overrun write also forwarded");
endmodule

// File: rtl/msi_irq.sv
module msi_irq
  import msi_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  input  logic [W-1:0] ier,
  output logic [W-1:0] status,
  output logic         irq_out
);
  logic [W-1:0] status_nx;
  logic [W-1:0] clr_vec;

  always_comb begin
    clr_vec   = clr_we ? clr_data : '0;
    status_nx = ((status & ~clr_vec) | ev_vec) & EV_MASK;
    irq_out   = |(status & ier);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_nx;
  end

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[B_OVR]) |-> $past(clr_we && clr_data[B_OVR]))
    else $error("overrun bit cleared without W1C");

  p_link_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[B_LINK]) |-> $past(clr_we && clr_data[B_LINK]))
    else $error("link bit cleared without W1C");

  p_irq_needs_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (status != '0)) else $error("irq with no status");
endmodule

// File: rtl/msi_regfile.sv
module msi_regfile
  import msi_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_en,
  input  logic         reg_we,
  input  logic [W-1:0] reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         cap_en,
  input  logic [W-1:0] cap_data,
  input  logic [W-1:0] status,
  output logic [W-1:0] mar,
  output logic [W-1:0] ier,
  output logic [W-1:0] mdr,
  output logic [W-1:0] bar_base,
  output logic [W-1:0] bar_mask,
  output logic         clr_we,
  output logic [W-1:0] clr_data
);
  logic         wr, rd;
  logic         mar_en, ier_en, base_en, mask_en;
  logic [W-1:0] rd_val, rdata_nx;

  always_comb begin
    wr       = reg_en && reg_we;
    rd       = reg_en && !reg_we;
    mar_en   = wr && (reg_addr == OFS_MAR);
    ier_en   = wr && (reg_addr == OFS_IER);
    base_en  = wr && (reg_addr == OFS_BASE);
    mask_en  = wr && (reg_addr == OFS_MASK);
    clr_we   = wr && (reg_addr == OFS_STAT);
    clr_data = reg_wdata;
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT: rd_val = status;
      OFS_IER:  rd_val = ier;
      OFS_MAR:  rd_val = mar;
      OFS_MDR:  rd_val = mdr;
      OFS_BASE: rd_val = bar_base;
      OFS_MASK: rd_val = bar_mask;
      default:  rd_val = '0;
    endcase
    rdata_nx = rd ? rd_val : reg_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar      <= '0;
      ier      <= '0;
      bar_base <= '0;
      bar_mask <= '0;
    end else begin
      if (mar_en)  mar      <= reg_wdata;
      if (ier_en)  ier      <= reg_wdata & EV_MASK;
      if (base_en) bar_base <= reg_wdata;
      if (mask_en) bar_mask <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mdr <= '0;
    else if (cap_en) mdr <= cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rdata_nx;
  end

  p_ier_resv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ier & ~EV_MASK) == '0) else $error("reserved enable bit set");

  p_mdr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdr) |-> $past(cap_en)) else $error("msi data changed without match");

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd) |-> $stable(reg_rdata)) else $error("read data moved without read");
endmodule

// File: rtl/msi_wr_detect.sv
module msi_wr_detect
  import msi_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_is64,
  input  logic [31:0]  req_addr,
  input  logic [31:0]  req_data,
  output logic         fwd_valid,
  output logic [31:0]  fwd_addr,
  output logic [31:0]  fwd_data,
  output logic         msi_irq,
  input  logic         ev_poison,
  input  logic         ev_cmpl_abort,
  input  logic         ev_ncbe,
  input  logic         ev_link_down,
  input  logic         ev_bus_master,
  output logic         irq_out,
  input  logic         reg_en,
  input  logic         reg_we,
  input  logic [31:0]  reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sn = rst_pipe[SYNC_STAGES-1];

  wr_req_t      req;
  logic [W-1:0] mar, ier, mdr, bar_base, bar_mask, status;
  logic         cap_en, ovr_evt, clr_we;
  logic [W-1:0] clr_data, ev_vec;

  always_comb begin
    req.is64 = req_is64;
    req.addr = req_addr;
    req.data = req_data;
    ev_vec   = '0;
    ev_vec[B_POISON] = ev_poison;
    ev_vec[B_ABORT]  = ev_cmpl_abort;
    ev_vec[B_OVR]    = ovr_evt;
    ev_vec[B_NCBE]   = ev_ncbe;
    ev_vec[B_LINK]   = ev_link_down;
    ev_vec[B_BME]    = ev_bus_master;
  end

  msi_match u_match (
    .clk       (clk),
    .rst_n     (rst_sn),
    .req_valid (req_valid),
    .req       (req),
    .mar       (mar),
    .bar_base  (bar_base),
    .bar_mask  (bar_mask),
    .fwd_valid (fwd_valid),
    .fwd_addr  (fwd_addr),
    .fwd_data  (fwd_data),
    .msi_pulse (msi_irq),
    .cap_en    (cap_en),
    .ovr_evt   (ovr_evt)
  );

  msi_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cap_en    (cap_en),
    .cap_data  (req_data),
    .status    (status),
    .mar       (mar),
    .ier       (ier),
    .mdr       (mdr),
    .bar_base  (bar_base),
    .bar_mask  (bar_mask),
    .clr_we    (clr_we),
    .clr_data  (clr_data)
  );

  msi_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .ev_vec   (ev_vec),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .ier      (ier),
    .status   (status),
    .irq_out  (irq_out)
  );

  p_msi_data_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    msi_irq |-> (mdr == $past(req_data))) else $error("msi data mismatch");

  p_fwd_in_window_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    fwd_valid |-> (((fwd_addr ^ $past(bar_base)) & $past(bar_mask)) == '0))
    else $error("forwarded write outside window");
endmodule

// File: tb/msi_wr_detect_tb.sv
module msi_wr_detect_tb;
  localparam logic [31:0] A_STAT = 32'h40, A_IER = 32'h44, A_MAR = 32'h48,
                          A_MDR = 32'h4C, A_BASE = 32'h50, A_MASK = 32'h54;
  localparam logic [31:0] EVM = 32'h0002_1F00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_is64 = 0;
  logic [31:0] req_addr = 0, req_data = 0;
  logic fwd_valid, msi_irq, irq_out;
  logic [31:0] fwd_addr, fwd_data, reg_rdata;
  logic ev_poison = 0, ev_cmpl_abort = 0, ev_ncbe = 0, ev_link_down = 0, ev_bus_master = 0;
  logic reg_en = 0, reg_we = 0;
  logic [31:0] reg_addr = 0, reg_wdata = 0;

  int tests = 0, fails = 0;
  logic s_fwd, s_msi, s_msi2;
  logic [31:0] s_faddr, s_fdata, rd, exp_mdr;

  always #10 clk = ~clk;

  msi_wr_detect u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_en = 0; reg_we = 0;
  endtask

  task automatic reg_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk); d = reg_rdata; reg_en = 0;
  endtask

  task automatic send_req(input logic w, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); req_valid = 1; req_is64 = w; req_addr = a; req_data = d;
    @(negedge clk); s_fwd = fwd_valid; s_faddr = fwd_addr; s_fdata = fwd_data;
    s_msi = msi_irq; req_valid = 0;
    @(negedge clk); s_msi2 = msi_irq;
  endtask

  task automatic set_ev(input int b, input logic v);
    case (b)
      8:  ev_poison = v;
      9:  ev_cmpl_abort = v;
      11: ev_ncbe = v;
      12: ev_link_down = v;
      default: ev_bus_master = v;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 fwd_valid", {31'b0, fwd_valid}, 0);
    chk("R1 msi_irq", {31'b0, msi_irq}, 0);
    chk("R1 irq_out", {31'b0, irq_out}, 0);
    foreach (A_LIST[i]) begin
      reg_read(A_LIST[i], rd);
      chk($sformatf("R1 reg %h", A_LIST[i]), rd, 0);
    end

    // window 0x1000_0000 .. 4 KB
    reg_write(A_BASE, 32'h1000_0000);
    reg_write(A_MASK, 32'hFFFF_F000);
    exp_mdr = 0;

    // all combos of header form, window hit, MSI hit
    for (int c = 0; c < 8; c++) begin
      logic w, inb, mt, msi, ovr;
      logic [31:0] mar, a, d;
      string tg;
      w = c[0]; inb = c[1]; mt = c[2];
      mar = inb ? 32'h1000_0040 : 32'h2000_0040;
      reg_write(A_MAR, mar);
      a = mt ? mar : (inb ? 32'h1000_0080 : 32'h3000_0000);
      d = 32'hA500_0000 | c;
      msi = mt && !w;
      ovr = !inb && !msi;
      tg = w ? "R3" : (mt && inb) ? "R5" : (mt ? "R7" : "R4");
      send_req(w, a, d);
      chk({tg, " fwd_valid"}, {31'b0, s_fwd}, {31'b0, inb});
      if (inb) begin
        chk("R4 fwd_addr", s_faddr, a);
        chk("R4 fwd_data", s_fdata, d);
      end
      chk({tg, " msi pulse"}, {31'b0, s_msi}, {31'b0, msi});
      chk("R2 pulse one cycle", {31'b0, s_msi2}, 0);
      if (msi) exp_mdr = d;
      reg_read(A_MDR, rd);
      chk({tg, " msi data"}, rd, exp_mdr);
      reg_read(A_STAT, rd);
      chk(ovr ? "R6 overrun set" : "R7 overrun clear", rd & 32'h400, ovr ? 32'h400 : 0);
      reg_write(A_STAT, 32'hFFFF_FFFF);
    end

    // single-bit flips around an in-window MSI address
    reg_write(A_MAR, 32'h1000_0040);
    for (int b = 0; b < 32; b++) begin
      logic [31:0] a;
      a = 32'h1000_0040 ^ (32'h1 << b);
      send_req(0, a, 32'h5A00_0000 | b);
      chk("R2 near miss", {31'b0, s_msi}, 0);
      chk("R4 mask bit", {31'b0, s_fwd}, (b < 12) ? 1 : 0);
      reg_read(A_STAT, rd);
      chk("R6 overrun on flip", rd & 32'h400, (b < 12) ? 0 : 32'h400);
      reg_write(A_STAT, 32'h400);
    end
    reg_read(A_MDR, rd);
    chk("R2 mdr held", rd, exp_mdr);

    // R8 enable register sweep
    for (int b = 0; b < 32; b++) begin
      reg_write(A_IER, 32'h1 << b);
      reg_read(A_IER, rd);
      chk("R8 enable bit", rd, (32'h1 << b) & EVM);
    end
    reg_write(A_IER, 32'hFFFF_FFFF);
    reg_read(A_IER, rd);
    chk("R8 enable all", rd, EVM);
    reg_write(A_IER, 0);

    // R9 / R10 events
    for (int b = 8; b < 18; b++) begin
      if (!EVM[b] || b == 10) continue;
      @(negedge clk); set_ev(b, 1);
      @(negedge clk); set_ev(b, 0);
      chk("R10 masked no irq", {31'b0, irq_out}, 0);
      repeat (3) @(negedge clk);
      reg_read(A_STAT, rd);
      chk("R9 sticky status", rd, 32'h1 << b);
      reg_write(A_IER, 32'h400);
      chk("R10 other enable no irq", {31'b0, irq_out}, 0);
      reg_write(A_IER, 32'h1 << b);
      chk("R10 enabled irq", {31'b0, irq_out}, 1);
      reg_write(A_STAT, 32'h1 << b);
      chk("R9 w1c clears irq", {31'b0, irq_out}, 0);
      reg_write(A_IER, 0);
    end

    // R9 set wins over same-cycle clear
    @(negedge clk); ev_link_down = 1; reg_en = 1; reg_we = 1;
    reg_addr = A_STAT; reg_wdata = 32'h1000;
    @(negedge clk); ev_link_down = 0; reg_en = 0; reg_we = 0;
    reg_read(A_STAT, rd);
    chk("R9 set beats clear", rd, 32'h1000);
    reg_write(A_STAT, 32'h1000);

    // R10 overrun through enable
    reg_write(A_IER, 32'h400);
    send_req(0, 32'h7000_0000, 32'h1);
    chk("R10 overrun irq", {31'b0, irq_out}, 1);
    reg_write(A_STAT, 32'h400);
    reg_write(A_IER, 0);

    // R11 undefined offsets and read-only MSI data
    reg_read(32'h0, rd);            chk("R11 offset 0", rd, 0);
    reg_read(32'h58, rd);           chk("R11 offset 58", rd, 0);
    reg_read(32'h148, rd);          chk("R11 offset 148", rd, 0);
    reg_write(A_MDR, 32'hDEAD_BEEF);
    reg_read(A_MDR, rd);            chk("R11 mdr read-only", rd, exp_mdr);

    // R12 read latency
    reg_write(A_MAR, 32'h1234_5678);
    reg_read(A_IER, rd);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = A_MAR;
    #1 chk("R12 rdata before edge", reg_rdata, 0);
    @(negedge clk); reg_en = 0;
    chk("R12 rdata after edge", reg_rdata, 32'h1234_5678);
    repeat (2) @(negedge clk);
    chk("R12 rdata holds", reg_rdata, 32'h1234_5678);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [31:0] A_LIST [6] = '{32'h40, 32'h44, 32'h48, 32'h4C, 32'h50, 32'h54};
endmodule